// File: doc/BRIEF.md
# MOESI Snooping Coherence State Controller

This block keeps the coherence state of every line in one private, direct-mapped cache. Each line has a tag and one of five states: Modified, Owned, Exclusive, Shared or Invalid. It serves local processor requests one at a time. When a request needs the shared bus, the block raises a bus request, which can be a read, a read-for-ownership, an invalidate or a writeback. At the same time it answers transactions that other caches place on the bus.

State is kept per block and not per word. Two addresses that differ only in their offset bits therefore share one entry. The Owned state lets a dirty line be shared without first writing it to memory. A Modified, Owned or Exclusive holder answers snooped reads in place of memory by raising a supply response.

Addresses are byte addresses. With the default parameters the address is split into three fields:
- bits [4:0] are the offset within a 32-byte block;
- bits [6:5] are the set index (4 sets);
- bits [15:7] are the tag.

Top module: `moesi_coherence_ctrl`

## Requirements
- R1: After reset every line is Invalid. `cpu_ready` is 1, `bus_req_valid` is 0, and a snooped read of any address gives supply 0 and shared 0.
- R2: A read miss raises a bus read (command code 0) on the block-aligned request address. At the granting cycle the line fills as Exclusive if `bus_shared_in` is 0, or as Shared if it is 1. `cpu_done` then pulses in the following cycle.
- R3: A write miss raises a read-for-ownership (code 1) on the block-aligned address. The line then fills as Modified.
- R4: A read hit in any valid state completes without a bus request. A write hit on Modified completes without a bus request. A write hit on Exclusive moves the line to Modified without a bus request.
- R5: A write hit on Shared or Owned raises an invalidate (code 2) on the block address. At the grant the line moves to Modified.
- R6: A snooped read (`snoop_cmd` 0) that hits a valid line raises `snoop_shared` in the same cycle. A hit on Modified, Owned or Exclusive also raises `snoop_supply`. The state moves from Modified to Owned, and from Exclusive to Shared. Shared and Owned lines keep their state.
- R7: A snooped read-for-ownership (code 1) or invalidate (code 2) that hits a valid line raises `snoop_shared` and moves the line to Invalid. `snoop_supply` is raised only for a read-for-ownership that hits Modified or Owned.
- R8: A miss whose victim is Modified or Owned first raises a writeback (code 3) to the victim's block address, and only then the fill request. A victim that is Exclusive or Shared is replaced with no writeback.
- R9: Addresses that differ only in offset bits refer to the same line state. Every bus request address is block aligned.
- R10: If a snoop invalidates the line while a local invalidate is still pending, the block withdraws the invalidate and reissues the request as a read-for-ownership. The line then ends Modified.
- R11: `cpu_ready` is 1 only while no request is in progress. `cpu_done` is a single-cycle pulse, once per request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cpu_req_valid | input | 1 | Local request, sampled while cpu_ready is 1 |
| cpu_req_write | input | 1 | 1 = write, 0 = read |
| cpu_req_addr | input | ADDR_W | Local byte address |
| cpu_ready | output | 1 | Idle, can accept a request |
| cpu_done | output | 1 | Request completed (one-cycle pulse) |
| bus_req_valid | output | 1 | Bus request pending |
| bus_req_cmd | output | 2 | 0 read, 1 read-for-ownership, 2 invalidate, 3 writeback |
| bus_req_addr | output | ADDR_W | Block-aligned address of the request |
| bus_grant | input | 1 | Pending request is performed this cycle |
| bus_shared_in | input | 1 | Another cache holds the line (valid with grant) |
| snoop_valid | input | 1 | Another cache's transaction is on the bus |
| snoop_cmd | input | 2 | Snooped command, same encoding as bus_req_cmd |
| snoop_addr | input | ADDR_W | Snooped byte address |
| snoop_supply | output | 1 | This cache provides the data in place of memory |
| snoop_shared | output | 1 | This cache holds the snooped line |

## Verification
The assertions take three things for granted about the inputs:
- `bus_grant` rises only while `bus_req_valid` is high.
- The bus never grants our own request in the same cycle as a snoop, so no snoop coincides with a grant.
- `cpu_req_valid` is offered only while `cpu_ready` is 1.

Under those assumptions the assertions expect a pending request to hold its command and address until it is granted or a snoop intervenes. The stimulus keeps within the assumptions in three ways:
- It drives grants only after it has seen a request.
- It issues snoops only while the processor side is idle, or while a request waits ungranted.
- It raises a local request only after checking that `cpu_ready` is 1.

// File: rtl/moesi_pkg.sv
package moesi_pkg;

  typedef enum logic [2:0] {
    ST_INV = 3'd0,
    ST_SHR = 3'd1,
    ST_EXC = 3'd2,
    ST_OWN = 3'd3,
    ST_MOD = 3'd4
  } coh_state_e;

  typedef enum logic [1:0] {
    CMD_READ  = 2'd0,
    CMD_RFO   = 2'd1,
    CMD_INVAL = 2'd2,
    CMD_WBACK = 2'd3
  } bus_cmd_e;

  // line holds a copy
  function automatic logic st_present(coh_state_e s);
    return s != ST_INV;
  endfunction

  // memory is stale: eviction needs a writeback
  function automatic logic st_dirty(coh_state_e s);
    return (s == ST_MOD) || (s == ST_OWN);
  endfunction

  // line may be written with no bus transaction
  function automatic logic st_writable(coh_state_e s);
    return (s == ST_MOD) || (s == ST_EXC);
  endfunction

  // state reached after another cache's transaction hits this line
  function automatic coh_state_e after_snoop(coh_state_e s, bus_cmd_e c);
    coh_state_e r;
    r = s;
    case (c)
      CMD_READ: begin
        if (s == ST_MOD) r = ST_OWN;
        else if (s == ST_EXC) r = ST_SHR;
      end
      CMD_RFO, CMD_INVAL: r = ST_INV;
      default: r = s;
    endcase
    return r;
  endfunction

  // this cache must answer the snoop with data
  function automatic logic must_supply(coh_state_e s, bus_cmd_e c);
    logic r;
    case (c)
      CMD_READ: r = (s == ST_MOD) || (s == ST_OWN) || (s == ST_EXC);
      CMD_RFO:  r = (s == ST_MOD) || (s == ST_OWN);
      default:  r = 1'b0;
    endcase
    return r;
  endfunction

  // state of a freshly filled line
  function automatic coh_state_e fill_state(logic for_write, logic others_share);
    coh_state_e r;
    if (for_write) r = ST_MOD;
    else if (others_share) r = ST_SHR;
    else r = ST_EXC;
    return r;
  endfunction

endpackage

// File: rtl/moesi_line_array.sv
module moesi_line_array
  import moesi_pkg::*;
#(
  parameter int SETS  = 4,
  parameter int TAG_W = 9,
  localparam int IDX_W = $clog2(SETS)
) (
  input  logic             clk,
  input  logic             rst_n,
  // port A: local side, read and full write
  input  logic [IDX_W-1:0] a_idx,
  output coh_state_e       a_state,
  output logic [TAG_W-1:0] a_tag,
  input  logic             a_we,
  input  coh_state_e       a_state_new,
  input  logic [TAG_W-1:0] a_tag_new,
  // port B: snoop side, read and state write
  input  logic [IDX_W-1:0] b_idx,
  output coh_state_e       b_state,
  output logic [TAG_W-1:0] b_tag,
  input  logic             b_we,
  input  coh_state_e       b_state_new
);

  logic [SETS-1:0][2:0]       st_flat;
  logic [SETS-1:0][TAG_W-1:0] tag_flat;

  for (genvar g = 0; g < SETS; g++) begin : g_set
    coh_state_e       st_r;
    logic [TAG_W-1:0] tag_r;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        st_r  <= ST_INV;
        tag_r <= '0;
      end else if (b_we && (b_idx == IDX_W'(g))) begin
        st_r <= b_state_new;
      end else if (a_we && (a_idx == IDX_W'(g))) begin
        st_r  <= a_state_new;
        tag_r <= a_tag_new;
      end
    end

    assign st_flat[g]  = st_r;
    assign tag_flat[g] = tag_r;
  end

  assign a_state = coh_state_e'(st_flat[a_idx]);
  assign a_tag   = tag_flat[a_idx];
  assign b_state = coh_state_e'(st_flat[b_idx]);
  assign b_tag   = tag_flat[b_idx];

endmodule

// File: rtl/moesi_snoop_resp.sv
module moesi_snoop_resp
  import moesi_pkg::*;
#(
  parameter int TAG_W = 9
) (
  input  logic             snoop_valid,
  input  bus_cmd_e         snoop_cmd,
  input  logic [TAG_W-1:0] snoop_tag,
  input  coh_state_e       line_state,
  input  logic [TAG_W-1:0] line_tag,
  output logic             supply,
  output logic             shared,
  output logic             st_we,
  output coh_state_e       st_next,
  output logic             ev_snoop_hit
);

  assign ev_snoop_hit = snoop_valid && st_present(line_state) && (line_tag == snoop_tag);
  assign supply       = ev_snoop_hit && must_supply(line_state, snoop_cmd);
  assign shared       = ev_snoop_hit;
  assign st_we        = ev_snoop_hit;
  assign st_next      = after_snoop(line_state, snoop_cmd);

endmodule

// File: rtl/moesi_req_fsm.sv
module moesi_req_fsm
  import moesi_pkg::*;
#(
  parameter int TAG_W    = 9,
  parameter int IDX_W    = 2,
  parameter int OFFSET_W = 5,
  localparam int ADDR_W  = TAG_W + IDX_W + OFFSET_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req_valid,
  input  logic              cpu_req_write,
  input  logic [TAG_W-1:0]  cpu_req_tag,
  input  logic [IDX_W-1:0]  cpu_req_idx,
  output logic              cpu_ready,
  output logic              cpu_done,
  output logic [IDX_W-1:0]  look_idx,
  input  coh_state_e        look_state,
  input  logic [TAG_W-1:0]  look_tag,
  output logic              loc_we,
  output coh_state_e        loc_state,
  output logic [TAG_W-1:0]  loc_tag,
  output logic              bus_req_valid,
  output bus_cmd_e          bus_req_cmd,
  output logic [ADDR_W-1:0] bus_req_addr,
  input  logic              bus_grant,
  input  logic              bus_shared_in,
  input  logic              snoop_busy,
  output logic              ev_bus_done,
  output logic              ev_need_lost
);

  typedef enum logic [1:0] {PH_IDLE, PH_CHECK, PH_BUS} phase_e;

  phase_e           ph_q, ph_d;
  bus_cmd_e         cmd_q, cmd_d;
  logic             wr_q;
  logic [TAG_W-1:0] tag_q;
  logic [IDX_W-1:0] idx_q;
  logic             done_q;
  logic             fin;
  logic             line_hit;
  logic             still_needed;

  assign look_idx = idx_q;
  assign line_hit = st_present(look_state) && (look_tag == tag_q);

  // pending transaction still meaningful after any snoop
  always_comb begin
    case (cmd_q)
      CMD_WBACK: still_needed = st_dirty(look_state);
      CMD_INVAL: still_needed = line_hit && !st_writable(look_state);
      default:   still_needed = 1'b1;
    endcase
  end

  always_comb begin
    ph_d      = ph_q;
    cmd_d     = cmd_q;
    fin       = 1'b0;
    loc_we    = 1'b0;
    loc_state = look_state;
    loc_tag   = look_tag;
    case (ph_q)
      PH_IDLE: begin
        if (cpu_req_valid) ph_d = PH_CHECK;
      end
      PH_CHECK: begin
        if (!snoop_busy) begin
          if (line_hit) begin
            if (!wr_q || (look_state == ST_MOD)) begin
              fin  = 1'b1;
              ph_d = PH_IDLE;
            end else if (look_state == ST_EXC) begin
              loc_we    = 1'b1;
              loc_state = ST_MOD;
              fin       = 1'b1;
              ph_d      = PH_IDLE;
            end else begin
              cmd_d = CMD_INVAL;
              ph_d  = PH_BUS;
            end
          end else if (st_dirty(look_state)) begin
            cmd_d = CMD_WBACK;
            ph_d  = PH_BUS;
          end else begin
            cmd_d = wr_q ? CMD_RFO : CMD_READ;
            ph_d  = PH_BUS;
          end
        end
      end
      PH_BUS: begin
        if (!still_needed) begin
          ph_d = PH_CHECK;
        end else if (bus_grant) begin
          loc_we = 1'b1;
          case (cmd_q)
            CMD_WBACK: begin
              loc_state = ST_INV;
              ph_d      = PH_CHECK;
            end
            CMD_INVAL: begin
              loc_state = ST_MOD;
              fin       = 1'b1;
              ph_d      = PH_IDLE;
            end
            default: begin
              loc_state = fill_state(cmd_q == CMD_RFO, bus_shared_in);
              loc_tag   = tag_q;
              fin       = 1'b1;
              ph_d      = PH_IDLE;
            end
          endcase
        end
      end
      default: ph_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q   <= PH_IDLE;
      cmd_q  <= CMD_READ;
      wr_q   <= 1'b0;
      tag_q  <= '0;
      idx_q  <= '0;
      done_q <= 1'b0;
    end else begin
      ph_q   <= ph_d;
      cmd_q  <= cmd_d;
      done_q <= fin;
      if ((ph_q == PH_IDLE) && cpu_req_valid) begin
        wr_q  <= cpu_req_write;
        tag_q <= cpu_req_tag;
        idx_q <= cpu_req_idx;
      end
    end
  end

  assign cpu_ready     = (ph_q == PH_IDLE);
  assign cpu_done      = done_q;
  assign bus_req_valid = (ph_q == PH_BUS) && still_needed;
  assign bus_req_cmd   = cmd_q;
  assign bus_req_addr  = {((cmd_q == CMD_WBACK) ? look_tag : tag_q), idx_q, OFFSET_W'(0)};
  assign ev_bus_done   = bus_req_valid && bus_grant;
  assign ev_need_lost  = (ph_q == PH_BUS) && !still_needed;

endmodule

// File: rtl/moesi_coherence_ctrl.sv
module moesi_coherence_ctrl
  import moesi_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int OFFSET_W = 5,
  parameter int SETS     = 4,
  localparam int IDX_W   = $clog2(SETS),
  localparam int TAG_W   = ADDR_W - OFFSET_W - IDX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req_valid,
  input  logic              cpu_req_write,
  input  logic [ADDR_W-1:0] cpu_req_addr,
  output logic              cpu_ready,
  output logic              cpu_done,
  output logic              bus_req_valid,
  output logic [1:0]        bus_req_cmd,
  output logic [ADDR_W-1:0] bus_req_addr,
  input  logic              bus_grant,
  input  logic              bus_shared_in,
  input  logic              snoop_valid,
  input  logic [1:0]        snoop_cmd,
  input  logic [ADDR_W-1:0] snoop_addr,
  output logic              snoop_supply,
  output logic              snoop_shared
);

  logic [TAG_W-1:0] req_tag, snp_tag;
  logic [IDX_W-1:0] req_idx, snp_idx, look_idx;
  coh_state_e       look_state, snp_line_state, loc_state, snp_state_new;
  logic [TAG_W-1:0] look_tag, snp_line_tag, loc_tag;
  logic             loc_we, snp_we;
  bus_cmd_e         fsm_cmd;
  logic             ev_bus_done, ev_need_lost, ev_snoop_hit;
  logic             unused_offset_bits;

  assign req_tag = cpu_req_addr[ADDR_W-1 -: TAG_W];
  assign req_idx = cpu_req_addr[OFFSET_W +: IDX_W];
  assign snp_tag = snoop_addr[ADDR_W-1 -: TAG_W];
  assign snp_idx = snoop_addr[OFFSET_W +: IDX_W];
  assign unused_offset_bits = ^{cpu_req_addr[OFFSET_W-1:0], snoop_addr[OFFSET_W-1:0]};

  moesi_line_array #(.SETS(SETS), .TAG_W(TAG_W)) u_lines (
    .clk        (clk),
    .rst_n      (rst_n),
    .a_idx      (look_idx),
    .a_state    (look_state),
    .a_tag      (look_tag),
    .a_we       (loc_we),
    .a_state_new(loc_state),
    .a_tag_new  (loc_tag),
    .b_idx      (snp_idx),
    .b_state    (snp_line_state),
    .b_tag      (snp_line_tag),
    .b_we       (snp_we),
    .b_state_new(snp_state_new)
  );

  moesi_snoop_resp #(.TAG_W(TAG_W)) u_snoop (
    .snoop_valid (snoop_valid),
    .snoop_cmd   (bus_cmd_e'(snoop_cmd)),
    .snoop_tag   (snp_tag),
    .line_state  (snp_line_state),
    .line_tag    (snp_line_tag),
    .supply      (snoop_supply),
    .shared      (snoop_shared),
    .st_we       (snp_we),
    .st_next     (snp_state_new),
    .ev_snoop_hit(ev_snoop_hit)
  );

  moesi_req_fsm #(.TAG_W(TAG_W), .IDX_W(IDX_W), .OFFSET_W(OFFSET_W)) u_fsm (
    .clk          (clk),
    .rst_n        (rst_n),
    .cpu_req_valid(cpu_req_valid),
    .cpu_req_write(cpu_req_write),
    .cpu_req_tag  (req_tag),
    .cpu_req_idx  (req_idx),
    .cpu_ready    (cpu_ready),
    .cpu_done     (cpu_done),
    .look_idx     (look_idx),
    .look_state   (look_state),
    .look_tag     (look_tag),
    .loc_we       (loc_we),
    .loc_state    (loc_state),
    .loc_tag      (loc_tag),
    .bus_req_valid(bus_req_valid),
    .bus_req_cmd  (fsm_cmd),
    .bus_req_addr (bus_req_addr),
    .bus_grant    (bus_grant),
    .bus_shared_in(bus_shared_in),
    .snoop_busy   (snoop_valid),
    .ev_bus_done  (ev_bus_done),
    .ev_need_lost (ev_need_lost)
  );

  assign bus_req_cmd = fsm_cmd;

endmodule

// File: rtl/moesi_checker.sv
module moesi_checker #(
  parameter int ADDR_W   = 16,
  parameter int OFFSET_W = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cpu_ready,
  input logic              cpu_done,
  input logic              bus_req_valid,
  input logic [1:0]        bus_req_cmd,
  input logic [ADDR_W-1:0] bus_req_addr,
  input logic              bus_grant,
  input logic              snoop_valid,
  input logic [1:0]        snoop_cmd,
  input logic              snoop_supply,
  input logic              snoop_shared,
  input logic              ev_bus_done,
  input logic              ev_need_lost,
  input logic              ev_snoop_hit
);

  AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req_valid |-> !cpu_ready); // R11

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_done |=> !cpu_done); // R11

  AST_SUPPLY_ON_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    snoop_supply |-> (snoop_valid && snoop_shared && ev_snoop_hit)); // R6

  AST_INVAL_NO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    (snoop_valid && (snoop_cmd == 2'd2)) |-> !snoop_supply); // R7

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req_valid && !bus_grant && !snoop_valid) |=>
      (bus_req_valid && $stable(bus_req_cmd) && $stable(bus_req_addr))); // R8

  AST_BLOCK_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req_valid |-> (bus_req_addr[OFFSET_W-1:0] == '0)); // R9

  AST_FILL_FINISHES: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_bus_done && (bus_req_cmd != 2'd3)) |=> cpu_done); // R2

  AST_WBACK_CONTINUES: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_bus_done && (bus_req_cmd == 2'd3)) |=> (!cpu_done && !cpu_ready)); // R8

  AST_LOST_REQ_RETRIES: assert property (@(posedge clk) disable iff (!rst_n)
    ev_need_lost |=> (!cpu_done && !cpu_ready)); // R10

endmodule

bind moesi_coherence_ctrl moesi_checker #(.ADDR_W(ADDR_W), .OFFSET_W(OFFSET_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .cpu_ready    (cpu_ready),
  .cpu_done     (cpu_done),
  .bus_req_valid(bus_req_valid),
  .bus_req_cmd  (bus_req_cmd),
  .bus_req_addr (bus_req_addr),
  .bus_grant    (bus_grant),
  .snoop_valid  (snoop_valid),
  .snoop_cmd    (snoop_cmd),
  .snoop_supply (snoop_supply),
  .snoop_shared (snoop_shared),
  .ev_bus_done  (ev_bus_done),
  .ev_need_lost (ev_need_lost),
  .ev_snoop_hit (ev_snoop_hit)
);

// File: tb/tb_moesi_coherence_ctrl.sv
module tb_moesi_coherence_ctrl;

  localparam logic [2:0] K_RD = 3'd0, K_WR = 3'd1, K_SRD = 3'd2, K_SRFO = 3'd3, K_SINV = 3'd4;
  localparam logic [2:0] C_RD = 3'd0, C_RFO = 3'd1, C_INV = 3'd2, C_WB = 3'd3, C_NONE = 3'd4;

  typedef struct packed {
    logic [2:0]  kind;
    logic [15:0] addr;
    logic        shr;
    logic [2:0]  c1;
    logic [2:0]  c2;
    logic [15:0] vaddr;
    logic        sup;
    logic        shd;
    logic [3:0]  req;
  } vec_t;

  localparam int NVEC = 20;
  localparam vec_t VECS [NVEC] = '{
    '{K_RD,   16'h0FA0, 1'b0, C_RD,   C_NONE, 16'h0000, 1'b0, 1'b0, 4'd2},  // R2 miss -> E
    '{K_WR,   16'h0FAC, 1'b0, C_NONE, C_NONE, 16'h0000, 1'b0, 1'b0, 4'd9},  // R9 R4 same block, E->M silent
    '{K_SRD,  16'h0FA0, 1'b0, C_NONE, C_NONE, 16'h0000, 1'b1, 1'b1, 4'd6},  // R6 M supplies, -> O
    '{K_WR,   16'h0FA0, 1'b0, C_INV,  C_NONE, 16'h0000, 1'b0, 1'b0, 4'd5},  // R5 O -> invalidate -> M
    '{K_SRFO, 16'h0FAC, 1'b0, C_NONE, C_NONE, 16'h0000, 1'b1, 1'b1, 4'd7},  // R7 M supplies, -> I
    '{K_RD,   16'h0FA0, 1'b1, C_RD,   C_NONE, 16'h0000, 1'b0, 1'b0, 4'd2},  // R2 shared fill -> S
    '{K_SRD,  16'h0FA0, 1'b0, C_NONE, C_NONE, 16'h0000, 1'b0, 1'b1, 4'd6},  // R6 S no supply
    '{K_WR,   16'h0FA4, 1'b0, C_INV,  C_NONE, 16'h0000, 1'b0, 1'b0, 4'd5},  // R5 S -> M
    '{K_RD,   16'h1FA0, 1'b0, C_WB,   C_RD,   16'h0FA0, 1'b0, 1'b0, 4'd8},  // R8 dirty victim
    '{K_SINV, 16'h1FA0, 1'b0, C_NONE, C_NONE, 16'h0000, 1'b0, 1'b1, 4'd7},  // R7 E -> I
    '{K_SRD,  16'h1FA0, 1'b0, C_NONE, C_NONE, 16'h0000, 1'b0, 1'b0, 4'd7},  // R7 now invalid
    '{K_WR,   16'h2000, 1'b0, C_RFO,  C_NONE, 16'h0000, 1'b0, 1'b0, 4'd3},  // R3 write miss
    '{K_RD,   16'h2004, 1'b0, C_NONE, C_NONE, 16'h0000, 1'b0, 1'b0, 4'd4},  // R4 read hit M
    '{K_WR,   16'h201C, 1'b0, C_NONE, C_NONE, 16'h0000, 1'b0, 1'b0, 4'd4},  // R4 write hit M
    '{K_RD,   16'h2080, 1'b0, C_WB,   C_RD,   16'h2000, 1'b0, 1'b0, 4'd8},  // R8 dirty victim
    '{K_SRFO, 16'h2080, 1'b0, C_NONE, C_NONE, 16'h0000, 1'b0, 1'b1, 4'd7},  // R7 E no supply on rfo
    '{K_RD,   16'h3FE0, 1'b1, C_RD,   C_NONE, 16'h0000, 1'b0, 1'b0, 4'd2},  // R2 -> S
    '{K_RD,   16'h5FE0, 1'b0, C_RD,   C_NONE, 16'h0000, 1'b0, 1'b0, 4'd8},  // R8 clean victim, no WB
    '{K_SRD,  16'h5FE0, 1'b0, C_NONE, C_NONE, 16'h0000, 1'b1, 1'b1, 4'd6},  // R6 E supplies, -> S
    '{K_SRD,  16'h3FE0, 1'b0, C_NONE, C_NONE, 16'h0000, 1'b0, 1'b0, 4'd9}   // R9 other tag misses
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cpu_req_valid = 1'b0, cpu_req_write = 1'b0;
  logic [15:0] cpu_req_addr = '0;
  logic        cpu_ready, cpu_done;
  logic        bus_req_valid;
  logic [1:0]  bus_req_cmd;
  logic [15:0] bus_req_addr;
  logic        bus_grant = 1'b0, bus_shared_in = 1'b0;
  logic        snoop_valid = 1'b0;
  logic [1:0]  snoop_cmd = '0;
  logic [15:0] snoop_addr = '0;
  logic        snoop_supply, snoop_shared;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #5 clk = ~clk;

  moesi_coherence_ctrl dut (
    .clk(clk), .rst_n(rst_n),
    .cpu_req_valid(cpu_req_valid), .cpu_req_write(cpu_req_write), .cpu_req_addr(cpu_req_addr),
    .cpu_ready(cpu_ready), .cpu_done(cpu_done),
    .bus_req_valid(bus_req_valid), .bus_req_cmd(bus_req_cmd), .bus_req_addr(bus_req_addr),
    .bus_grant(bus_grant), .bus_shared_in(bus_shared_in),
    .snoop_valid(snoop_valid), .snoop_cmd(snoop_cmd), .snoop_addr(snoop_addr),
    .snoop_supply(snoop_supply), .snoop_shared(snoop_shared)
  );

  task automatic check(input bit ok, input int rq, input logic [31:0] act,
                       input logic [31:0] exp, input string what);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL R%0d %s: actual %0h expected %0h", rq, what, act, exp);
    end
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 20000) begin
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    end
  end

  task automatic cpu_op(input logic wr, input logic [15:0] a, input logic shr,
                        input logic [2:0] c1, input logic [2:0] c2,
                        input logic [15:0] va, input int rq);
    int nreq;
    int nexp;
    bit got_done;
    logic [2:0] exp;
    logic [15:0] expa;
    @(negedge clk);
    check(cpu_ready == 1'b1, 11, {31'd0, cpu_ready}, 1, "ready before request");
    cpu_req_valid = 1'b1;
    cpu_req_write = wr;
    cpu_req_addr  = a;
    @(negedge clk);
    cpu_req_valid = 1'b0;
    nreq = 0;
    got_done = 1'b0;
    nexp = ((c1 != C_NONE) ? 1 : 0) + ((c2 != C_NONE) ? 1 : 0);
    for (int t = 0; t < 40 && !got_done; t++) begin
      if (cpu_done) begin
        got_done = 1'b1;
      end else if (bus_req_valid) begin
        exp  = (nreq == 0) ? c1 : ((nreq == 1) ? c2 : C_NONE);
        expa = (exp == C_WB) ? va : {a[15:5], 5'b0};
        check({1'b0, bus_req_cmd} == exp, rq, {29'd0, 1'b0, bus_req_cmd}, {29'd0, exp}, "bus command");
        check(bus_req_addr == expa, rq, {16'd0, bus_req_addr}, {16'd0, expa}, "bus address");
        check(cpu_ready == 1'b0, 11, {31'd0, cpu_ready}, 0, "ready while busy");
        nreq++;
        bus_grant = 1'b1;
        bus_shared_in = shr;
        @(negedge clk);
        bus_grant = 1'b0;
        bus_shared_in = 1'b0;
      end else begin
        @(negedge clk);
      end
    end
    check(got_done, rq, {31'd0, got_done}, 1, "request completed");
    check(nreq == nexp, rq, nreq, nexp, "bus request count");
    @(negedge clk);
    check(cpu_done == 1'b0, 11, {31'd0, cpu_done}, 0, "done is one pulse");
  endtask

  task automatic snoop_op(input logic [1:0] cmd, input logic [15:0] a,
                          input logic sup, input logic shd, input int rq);
    @(negedge clk);
    snoop_valid = 1'b1;
    snoop_cmd   = cmd;
    snoop_addr  = a;
    #1;
    check(snoop_supply == sup, rq, {31'd0, snoop_supply}, {31'd0, sup}, "snoop supply");
    check(snoop_shared == shd, rq, {31'd0, snoop_shared}, {31'd0, shd}, "snoop shared");
    @(negedge clk);
    snoop_valid = 1'b0;
  endtask

  initial begin
    bit seen;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    @(negedge clk);
    check(cpu_ready == 1'b1, 1, {31'd0, cpu_ready}, 1, "ready after reset");
    check(bus_req_valid == 1'b0, 1, {31'd0, bus_req_valid}, 0, "no bus request after reset");
    snoop_op(2'd0, 16'h0FA0, 1'b0, 1'b0, 1);

    for (int i = 0; i < NVEC; i++) begin
      case (VECS[i].kind)
        K_RD:    cpu_op(1'b0, VECS[i].addr, VECS[i].shr, VECS[i].c1, VECS[i].c2, VECS[i].vaddr, int'(VECS[i].req));
        K_WR:    cpu_op(1'b1, VECS[i].addr, VECS[i].shr, VECS[i].c1, VECS[i].c2, VECS[i].vaddr, int'(VECS[i].req));
        K_SRD:   snoop_op(2'd0, VECS[i].addr, VECS[i].sup, VECS[i].shd, int'(VECS[i].req));
        K_SRFO:  snoop_op(2'd1, VECS[i].addr, VECS[i].sup, VECS[i].shd, int'(VECS[i].req));
        default: snoop_op(2'd2, VECS[i].addr, VECS[i].sup, VECS[i].shd, int'(VECS[i].req));
      endcase
    end

    // R10 pending invalidate overtaken by a snooped read-for-ownership
    cpu_op(1'b0, 16'h0040, 1'b1, C_RD, C_NONE, 16'h0000, 2);
    @(negedge clk);
    cpu_req_valid = 1'b1;
    cpu_req_write = 1'b1;
    cpu_req_addr  = 16'h0040;
    @(negedge clk);
    cpu_req_valid = 1'b0;
    seen = 1'b0;
    for (int t = 0; t < 10 && !seen; t++) begin
      if (bus_req_valid) seen = 1'b1;
      else @(negedge clk);
    end
    check(seen && (bus_req_cmd == 2'd2), 5, {30'd0, bus_req_cmd}, 2, "invalidate raised on S write");
    snoop_valid = 1'b1;
    snoop_cmd   = 2'd1;
    snoop_addr  = 16'h0048;
    #1;
    check(snoop_supply == 1'b0, 10, {31'd0, snoop_supply}, 0, "S copy gives no data");
    check(snoop_shared == 1'b1, 10, {31'd0, snoop_shared}, 1, "S copy reports shared");
    @(negedge clk);
    snoop_valid = 1'b0;
    seen = 1'b0;
    for (int t = 0; t < 10 && !seen; t++) begin
      if (bus_req_valid && (bus_req_cmd == 2'd1)) seen = 1'b1;
      else @(negedge clk);
    end
    check(seen, 10, {31'd0, seen}, 1, "reissued as read-for-ownership");
    check(bus_req_addr == 16'h0040, 10, {16'd0, bus_req_addr}, 16'h0040, "reissue address");
    bus_grant = 1'b1;
    @(negedge clk);
    bus_grant = 1'b0;
    check(cpu_done == 1'b1, 10, {31'd0, cpu_done}, 1, "done after reissue");
    snoop_op(2'd0, 16'h0040, 1'b1, 1'b1, 10);

    // R1 reset in mid-run clears every line
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(cpu_ready == 1'b1, 1, {31'd0, cpu_ready}, 1, "ready after second reset");
    snoop_op(2'd0, 16'h0040, 1'b0, 1'b0, 1);
    snoop_op(2'd0, 16'h5FE0, 1'b0, 1'b0, 1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule